// File: doc/BRIEF.md
# Branch-Outcome L0 Fetch Steering Controller

This block sits beside the fetch unit of a processor that carries a small level-zero instruction cache in front of the ordinary I-cache. At every branch resolution it decides where the instructions of the basic blocks that follow should come from. It can name the L0, so that frequently executed code is captured there. It can name the I-cache, so that the L0 is bypassed and not polluted with rarely executed code. The decision is held until the next branch resolves.

The decision is made from the branch outcome (mispredicted or not) and from the verdict of a confidence estimator (high or low). One of four selectable policies is applied to these inputs. The plain policy trusts every correct prediction. The confidence policy bypasses the L0 after a confident miss or after a long streak of low-confidence branches. The restrictive policy admits only confident correct predictions. The distance policy keeps the L0 off until enough branches have passed since the last misprediction. The streak limit and the distance limit share one programmable threshold. The branch predictor and the confidence estimator are outside the block.

Top module: `l0_steer_ctrl`

## Requirements
- R1: With policy code 0 (plain), a resolved branch sets use_l0 to 1 if it was predicted correctly and to 0 if it was mispredicted.
- R2: With policy code 1 (confidence), a resolved branch that is both high-confidence and mispredicted sets use_l0 to 0.
- R3: A streak counter of CNT_W bits is cleared by every high-confidence branch and otherwise incremented by each resolved branch, saturating at 2^CNT_W-1. With policy code 1, use_l0 is set to 0 when the streak value that includes the current branch exceeds thresh.
- R4: With policy code 1, use_l0 is set to 1 when neither the R2 nor the R3 condition holds.
- R5: With policy code 2 (restrictive), use_l0 is set to 1 only for a branch that is high-confidence and predicted correctly; every other outcome sets it to 0.
- R6: A distance counter of CNT_W bits is cleared by a mispredicted branch and otherwise incremented by each resolved branch, saturating at 2^CNT_W-1. With policy code 3 (distance), use_l0 is set to 1 exactly when the counter value after this update exceeds thresh.
- R7: During reset and after it, use_l0 is 0 and both counters are 0.
- R8: use_l0 changes only at the clock edge that samples br_valid high. It is visible from the cycle after the strobe. In cycles without the strobe, use_l0 and both counters keep their values whatever the other inputs do.
- R9: Both counters are updated on every resolved branch, whichever policy is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch-resolution strobe, one cycle per branch |
| br_mispred | input | 1 | Resolved branch was mispredicted |
| br_hiconf | input | 1 | Estimator rated the branch high-confidence |
| policy | input | 2 | Policy select: 0 plain, 1 confidence, 2 restrictive, 3 distance |
| thresh | input | CNT_W | Streak and distance threshold n |
| use_l0 | output | 1 | 1: following fetches use the L0; 0: they go to the I-cache |

## Verification
The bench builds the block with CNT_W = 3, so the counters saturate at 7. Every threshold value from 0 to 7 can then be swept under every policy. Long pseudo-random branch streams reach both the saturation point and the threshold boundaries. Directed runs of ten low-confidence or ten correctly predicted branches at thresholds 6 and 7 show that a saturated counter never exceeds the largest threshold. Idle cycles with scrambled inputs between branches confirm that the output and the counters are held.

// File: rtl/l0s_pkg.sv
package l0s_pkg;

   typedef enum logic [1:0] {
      POL_PLAIN    = 2'd0,
      POL_CONF     = 2'd1,
      POL_RESTRICT = 2'd2,
      POL_DIST     = 2'd3
   } steer_pol_e;

endpackage

// File: rtl/l0s_sat_counter.sv
module l0s_sat_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clear,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_nxt
);
   localparam logic [W-1:0] CNT_MAX = '1;

   generate
      if (W < 1) begin : g_bad_width
         $error("l0s_sat_counter: W must be at least 1");
      end
   endgenerate

   always_comb begin
      if (clear)
         cnt_nxt = '0;
      else if (cnt_q == CNT_MAX)
         cnt_nxt = CNT_MAX;
      else
         cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step)
         cnt_q <= cnt_nxt;
   end

   // R3 / R6: clear wins on a branch
   p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && clear) |=> (cnt_q == '0));
   // R3 / R6: saturation
   p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
   // R8: held without a strobe
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));

endmodule

// File: rtl/l0s_decide.sv
module l0s_decide
   import l0s_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [1:0]   policy,
   input  logic         mispred,
   input  logic         hiconf,
   input  logic [W-1:0] streak_nxt,
   input  logic [W-1:0] dist_nxt,
   input  logic [W-1:0] thresh,
   output logic         want_l0
);
   steer_pol_e pol;
   logic       conf_miss;
   logic       long_streak;

   assign pol         = steer_pol_e'(policy);
   assign conf_miss   = hiconf && mispred;
   assign long_streak = (streak_nxt > thresh);

   always_comb begin
      unique case (pol)
         POL_PLAIN:    want_l0 = !mispred;
         POL_CONF:     want_l0 = !conf_miss && !long_streak;
         POL_RESTRICT: want_l0 = hiconf && !mispred;
         POL_DIST:     want_l0 = (dist_nxt > thresh);
         default:      want_l0 = 1'b0;
      endcase
   end

   // R2: a confident miss never selects the L0 under the confidence policy
   always_comb begin
      if (pol == POL_CONF && conf_miss)
         a_conf_miss_r2: assert (!want_l0);
   end

endmodule

// File: rtl/l0_steer_ctrl.sv
module l0_steer_ctrl
   import l0s_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             br_valid,
   input  logic             br_mispred,
   input  logic             br_hiconf,
   input  logic [1:0]       policy,
   input  logic [CNT_W-1:0] thresh,
   output logic             use_l0
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("l0_steer_ctrl: CNT_W must lie in 1..16");
      end
   endgenerate

   logic [CNT_W-1:0] streak_q, streak_nxt;
   logic [CNT_W-1:0] dist_q, dist_nxt;
   logic             want_l0;

   // low-confidence streak: cleared by a high-confidence branch
   l0s_sat_counter #(.W(CNT_W)) u_streak (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (br_valid),
      .clear   (br_hiconf),
      .cnt_q   (streak_q),
      .cnt_nxt (streak_nxt)
   );

   // distance from the last misprediction
   l0s_sat_counter #(.W(CNT_W)) u_dist (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (br_valid),
      .clear   (br_mispred),
      .cnt_q   (dist_q),
      .cnt_nxt (dist_nxt)
   );

   l0s_decide #(.W(CNT_W)) u_decide (
      .policy     (policy),
      .mispred    (br_mispred),
      .hiconf     (br_hiconf),
      .streak_nxt (streak_nxt),
      .dist_nxt   (dist_nxt),
      .thresh     (thresh),
      .want_l0    (want_l0)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         use_l0 <= 1'b0;
      else if (br_valid)
         use_l0 <= want_l0;
   end

   // R1
   p_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && policy == 2'd0) |=> (use_l0 == !$past(br_mispred)));
   // R5
   p_restrict_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && policy == 2'd2) |=> (use_l0 == $past(br_hiconf && !br_mispred)));
   // R2
   p_conf_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && policy == 2'd1 && br_hiconf && br_mispred) |=> !use_l0);
   // R6: a misprediction leaves the distance counter at zero, never above n
   p_dist_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && policy == 2'd3 && br_mispred) |=> !use_l0);
   // R8
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |=> $stable(use_l0));
   // R7
   always_ff @(posedge clk) begin
      if (rst_n && $past(!rst_n))
         a_reset_r7: assert (!use_l0 && streak_q == '0 && dist_q == '0);
   end

endmodule

// File: tb/l0_steer_ctrl_tb.sv
`timescale 1ns/1ps
module l0_steer_ctrl_tb;
   localparam int CW  = 3;
   localparam int MAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          br_valid = 1'b0;
   logic          br_mispred = 1'b0;
   logic          br_hiconf = 1'b0;
   logic [1:0]    policy = 2'd0;
   logic [CW-1:0] thresh = '0;
   logic          use_l0;

   int checks = 0;
   int fails  = 0;
   int m_streak = 0;
   int m_dist   = 0;
   bit m_use    = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   l0_steer_ctrl #(.CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_mispred(br_mispred),
      .br_hiconf(br_hiconf), .policy(policy), .thresh(thresh), .use_l0(use_l0)
   );

   task automatic check(input string tag, input bit exp);
      checks++;
      if (use_l0 !== exp) begin
         fails++;
         $display("FAIL %s pol=%0d n=%0d use_l0=%b expected=%b", tag, policy, thresh, use_l0, exp);
      end
   endtask

   function automatic bit rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // one resolved branch, with the model update (R9: counters always run)
   task automatic branch(input bit mis, input bit hi);
      string tag;
      bit    cmiss, lstreak;
      @(negedge clk);
      br_valid = 1'b1; br_mispred = mis; br_hiconf = hi;
      m_streak = hi ? 0 : ((m_streak == MAX) ? MAX : m_streak + 1);
      m_dist   = mis ? 0 : ((m_dist == MAX) ? MAX : m_dist + 1);
      cmiss    = hi && mis;
      lstreak  = (m_streak > int'(thresh));
      case (policy)
         2'd0: begin m_use = !mis; tag = "R1"; end
         2'd1: begin
            m_use = !cmiss && !lstreak;
            tag = cmiss ? "R2" : (lstreak ? "R3" : "R4");
         end
         2'd2: begin m_use = hi && !mis; tag = "R5"; end
         default: begin m_use = (m_dist > int'(thresh)); tag = "R6"; end
      endcase
      @(negedge clk);
      br_valid = 1'b0;
      check(tag, m_use);
   endtask

   // idle cycle with scrambled inputs: R8, output held
   task automatic idle();
      @(negedge clk);
      br_valid = 1'b0; br_mispred = rnd(); br_hiconf = rnd();
      @(negedge clk);
      check("R8", m_use);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; br_valid = 1'b0;
      repeat (2) @(negedge clk);
      check("R7", 1'b0);
      rst_n = 1'b1;
      m_streak = 0; m_dist = 0; m_use = 1'b0;
      @(negedge clk);
      check("R7", 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL R8 watchdog expired use_l0=%b expected=finish", use_l0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R7: zero counters visible: first low-conf correct branch, n=0
      policy = 2'd1; thresh = '0;
      branch(1'b0, 1'b0);   // streak 1 > 0 -> I-cache (R3)
      do_reset();
      policy = 2'd3;
      branch(1'b0, 1'b1);   // distance 1 > 0 -> L0 (R6)
      do_reset();

      // sweep every policy and threshold, R9 via shared model
      for (int p = 0; p < 4; p++) begin
         for (int n = 0; n <= MAX; n++) begin
            policy = p[1:0]; thresh = n[CW-1:0];
            for (int i = 0; i < 40; i++) begin
               bit m, h;
               m = rnd() & rnd();
               h = rnd() | rnd();
               if (i % 13 > 8) h = 1'b0;
               branch(m, h);
               if (i % 3 == 0) idle();
            end
         end
      end

      // saturation boundaries, R3
      policy = 2'd1;
      for (int n = MAX - 1; n <= MAX; n++) begin
         thresh = n[CW-1:0];
         branch(1'b0, 1'b1);
         for (int i = 0; i < 10; i++) branch(1'b0, 1'b0);
      end
      // saturation boundaries, R6
      policy = 2'd3;
      for (int n = MAX - 1; n <= MAX; n++) begin
         thresh = n[CW-1:0];
         branch(1'b1, 1'b0);
         for (int i = 0; i < 10; i++) branch(1'b0, 1'b0);
      end
      // counters held across idle cycles with a policy switch: R8, R9
      policy = 2'd1; thresh = 3'd2;
      branch(1'b0, 1'b1);
      branch(1'b0, 1'b0);
      policy = 2'd0; idle(); idle();
      policy = 2'd1;
      branch(1'b0, 1'b0);   // streak 2, not > 2 -> L0 (R4)
      branch(1'b0, 1'b0);   // streak 3 > 2 -> I-cache (R3)

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule